// File: doc/BRIEF.md
# Complex Multiply-Accumulate Butterfly Unit

This block is a one-cycle complex arithmetic datapath for signal-processing pipelines. It takes three signed fixed-point complex operands: a base term X, a data term Y and a coefficient W, each given as a real and an imaginary part. Four real multipliers run in parallel and one add/subtract pair combines their outputs. The adder stage then forms both radix-2 butterfly outputs, X plus the product and X minus the product, from a single evaluation of W·Y. No second multiply is needed for the difference.

A three-bit operation code picks the function for each accepted sample. The choices are a plain complex product and a complex multiply-accumulate into a wide guard-bit accumulator. There is also the butterfly, and two products with conjugated operands (conjugate of X times Y, and conjugate of X times conjugate of Y). Finally, a split mode runs the two halves of the multiplier array as two independent real products. Every result passes through a programmable arithmetic right shift of 0 to 3 bits and is then saturated to the operand width. A transform schedule can use the shift to absorb bit growth stage by stage.

Operands are captured on a valid strobe. The results and a result-valid strobe appear exactly one clock later.

Top module: `cplx_bfly_mac`

## Requirements
- R1: `outValid` rises in the cycle after a cycle with `inValid` high and is low otherwise. While `inValid` is low, the result outputs keep their last values.
- R2: Operation code 0 gives sum = W·Y, where real = wRe·yRe − wIm·yIm and imag = wRe·yIm + wIm·yRe. The difference outputs are 0. The accumulator is loaded with the unshifted product.
- R3: Operation code 2 gives sum = X + W·Y and difference = X − W·Y in the same result cycle.
- R4: Operation code 1 adds W·Y to the accumulator, part by part. Each part saturates at the signed ACC_W-bit limits instead of wrapping. The sum outputs report the new accumulator value after the shift and the output saturation.
- R5: `accClear` with `inValid` low sets both accumulator parts to 0. `accClear` together with operation code 1 makes the accumulator equal to that product alone.
- R6: Operation code 3 gives sum = conj(X)·Y: the sign of xIm is inverted before the multiply. The difference outputs are 0.
- R7: Operation code 4 gives sum = conj(X)·conj(Y): the signs of both xIm and yIm are inverted. The difference outputs are 0.
- R8: Operation code 5 gives sumRe = xRe·yRe and sumIm = xIm·yIm as two separate real products. W is unused and the difference outputs are 0.
- R9: Each result is arithmetically shifted right by `shiftAmt` (0 to 3, rounding toward minus infinity). It is then clamped to the range −2^(DATA_W−1) to 2^(DATA_W−1)−1.
- R10: Operation codes 6 and 7 give all four result outputs 0 and set `opErr` for that result. They leave the accumulator unchanged. `opErr` is cleared by the next valid operation with a defined code.
- R11: After reset, every output is 0.
- R12: Inverting the sign of a part equal to −2^(DATA_W−1) gives +2^(DATA_W−1) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands and operation code are valid this cycle |
| opCode | input | 3 | Operation select (0 mul, 1 mac, 2 butterfly, 3 conj, 4 double conj, 5 dual real) |
| shiftAmt | input | 2 | Right-shift amount applied to results |
| accClear | input | 1 | Clear the accumulator |
| xRe | input | DATA_W | X real part, signed |
| xIm | input | DATA_W | X imaginary part, signed |
| yRe | input | DATA_W | Y real part, signed |
| yIm | input | DATA_W | Y imaginary part, signed |
| wRe | input | DATA_W | W real part, signed |
| wIm | input | DATA_W | W imaginary part, signed |
| outValid | output | 1 | Results are valid |
| sumRe | output | DATA_W | Sum or product, real part |
| sumIm | output | DATA_W | Sum or product, imaginary part |
| difRe | output | DATA_W | Butterfly difference, real part |
| difIm | output | DATA_W | Butterfly difference, imaginary part |
| accRe | output | ACC_W | Accumulator, real part |
| accIm | output | ACC_W | Accumulator, imaginary part |
| opErr | output | 1 | Last valid operation code was undefined |

## Verification
A vector table drives each operation code with operands of mixed sign. Each operand pattern has a W whose real and imaginary parts differ and a Y with nonzero parts in both positions. This way a swapped multiplier pair, a wrong cross-term sign or a misplaced conjugation shows as a distinct wrong value. Butterfly vectors are run with shift 0 and with shift 1 on odd negative values, which separates a floor shift from truncation toward zero. Large products check that output saturation clamps in both directions. Directed sequences cover the following:
- the order of accumulation across several samples
- a clear given alone and a clear given together with an accumulate
- an error code that must leave the accumulator untouched
- a long run of full-scale accumulates that must stop at the accumulator limit
- a conjugate of the most negative value that must not wrap

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  typedef enum logic [2:0] {
    OP_MUL  = 3'd0,
    OP_MAC  = 3'd1,
    OP_BFLY = 3'd2,
    OP_CJ1  = 3'd3,
    OP_CJ2  = 3'd4,
    OP_DUAL = 3'd5
  } op_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;  // register results this cycle
    logic selXY;    // multiplier operands from X,Y instead of W,Y
    logic conjA;    // negate imaginary part of first operand
    logic conjB;    // negate imaginary part of second operand
    logic accLoad;  // accumulator <= product
    logic accAdd;   // accumulator <= base + product
    logic accZero;  // base is zero / clear accumulator
    logic bfly;     // sum/difference with X
    logic dual;     // two independent real lanes
    logic macOut;   // report accumulator on sum outputs
    logic bad;      // undefined operation code
  } ctrl_t;

endpackage

// File: rtl/cbm_ctrl.sv
module cbm_ctrl
  import cbm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic [2:0] opCode,
  input  logic       accClear,
  output ctrl_t      ctrl,
  output logic       outValid,
  output logic       opErr
);

  logic isBad;

  always_comb begin
    isBad        = (opCode > OP_DUAL);
    ctrl         = '0;
    ctrl.capture = inValid;
    ctrl.accZero = accClear;
    ctrl.bad     = isBad;
    unique case (opCode)
      OP_MUL:  ctrl.accLoad = inValid;
      OP_MAC:  begin ctrl.accAdd = inValid; ctrl.macOut = 1'b1; end
      OP_BFLY: ctrl.bfly = 1'b1;
      OP_CJ1:  begin ctrl.selXY = 1'b1; ctrl.conjA = 1'b1; end
      OP_CJ2:  begin ctrl.selXY = 1'b1; ctrl.conjA = 1'b1; ctrl.conjB = 1'b1; end
      OP_DUAL: begin ctrl.selXY = 1'b1; ctrl.dual = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      opErr    <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) opErr <= isBad;
    end
  end

endmodule

// File: rtl/cbm_datapath.sv
module cbm_datapath
  import cbm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctrl_t                    ctrl,
  input  logic [1:0]               shiftAmt,
  input  logic signed [DATA_W-1:0] xRe,
  input  logic signed [DATA_W-1:0] xIm,
  input  logic signed [DATA_W-1:0] yRe,
  input  logic signed [DATA_W-1:0] yIm,
  input  logic signed [DATA_W-1:0] wRe,
  input  logic signed [DATA_W-1:0] wIm,
  output logic signed [DATA_W-1:0] sumRe,
  output logic signed [DATA_W-1:0] sumIm,
  output logic signed [DATA_W-1:0] difRe,
  output logic signed [DATA_W-1:0] difIm,
  output logic signed [ACC_W-1:0]  accRe,
  output logic signed [ACC_W-1:0]  accIm
);

  localparam int W1    = DATA_W + 1;   // room for negating the minimum value
  localparam int PW    = 2 * W1;       // full product width
  localparam int CW    = PW + 1;       // complex part width
  localparam int EXT_W = ACC_W + 1;    // common working width
  localparam int LANES = 4;

  localparam logic signed [EXT_W-1:0] OUT_MAX = {{(EXT_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] OUT_MIN = {{(EXT_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic signed [EXT_W-1:0] ACC_MAX = {2'b00, {(ACC_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] ACC_MIN = {2'b11, {(ACC_W-1){1'b0}}};

  function automatic logic signed [DATA_W-1:0] shiftSat(input logic signed [EXT_W-1:0] v,
                                                        input logic [1:0] sh);
    logic signed [EXT_W-1:0] s;
    s = v >>> sh;
    if (s > OUT_MAX)      shiftSat = OUT_MAX[DATA_W-1:0];
    else if (s < OUT_MIN) shiftSat = OUT_MIN[DATA_W-1:0];
    else                  shiftSat = s[DATA_W-1:0];
  endfunction

  function automatic logic signed [ACC_W-1:0] accSat(input logic signed [EXT_W-1:0] v);
    if (v > ACC_MAX)      accSat = ACC_MAX[ACC_W-1:0];
    else if (v < ACC_MIN) accSat = ACC_MIN[ACC_W-1:0];
    else                  accSat = v[ACC_W-1:0];
  endfunction

  // Operand selection with optional conjugation.
  logic signed [W1-1:0] aRe, aIm, bRe, bIm;
  always_comb begin
    if (ctrl.selXY) begin
      aRe = W1'(xRe);
      aIm = ctrl.conjA ? -W1'(xIm) : W1'(xIm);
    end else begin
      aRe = W1'(wRe);
      aIm = W1'(wIm);
    end
    bRe = W1'(yRe);
    bIm = ctrl.conjB ? -W1'(yIm) : W1'(yIm);
  end

  // Four parallel real multipliers: rr, ii, ri, ir.
  logic signed [W1-1:0] opA [LANES];
  logic signed [W1-1:0] opB [LANES];
  logic signed [PW-1:0] prod [LANES];
  always_comb begin
    opA[0] = aRe; opB[0] = bRe;
    opA[1] = aIm; opB[1] = bIm;
    opA[2] = aRe; opB[2] = bIm;
    opA[3] = aIm; opB[3] = bRe;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_mult
    assign prod[g] = PW'(opA[g]) * PW'(opB[g]);
  end

  logic signed [CW-1:0] pRe, pIm;
  assign pRe = CW'(prod[0]) - CW'(prod[1]);
  assign pIm = CW'(prod[2]) + CW'(prod[3]);

  // Accumulator path.
  logic signed [EXT_W-1:0] baseRe, baseIm, accSumRe, accSumIm;
  logic signed [ACC_W-1:0] accNextRe, accNextIm;
  always_comb begin
    baseRe    = ctrl.accZero ? '0 : EXT_W'(accRe);
    baseIm    = ctrl.accZero ? '0 : EXT_W'(accIm);
    accSumRe  = baseRe + EXT_W'(pRe);
    accSumIm  = baseIm + EXT_W'(pIm);
    accNextRe = accSat(accSumRe);
    accNextIm = accSat(accSumIm);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accRe <= '0;
      accIm <= '0;
    end else if (ctrl.accAdd) begin
      accRe <= accNextRe;
      accIm <= accNextIm;
    end else if (ctrl.accLoad) begin
      accRe <= ACC_W'(pRe);
      accIm <= ACC_W'(pIm);
    end else if (ctrl.accZero) begin
      accRe <= '0;
      accIm <= '0;
    end
  end

  // Result selection: lanes 0..3 = sumRe, sumIm, difRe, difIm.
  logic signed [EXT_W-1:0]  wide   [LANES];
  logic signed [DATA_W-1:0] narrow [LANES];
  always_comb begin
    for (int i = 0; i < LANES; i++) wide[i] = '0;
    if (ctrl.bad) begin
      for (int i = 0; i < LANES; i++) wide[i] = '0;
    end else if (ctrl.bfly) begin
      wide[0] = EXT_W'(xRe) + EXT_W'(pRe);
      wide[1] = EXT_W'(xIm) + EXT_W'(pIm);
      wide[2] = EXT_W'(xRe) - EXT_W'(pRe);
      wide[3] = EXT_W'(xIm) - EXT_W'(pIm);
    end else if (ctrl.macOut) begin
      wide[0] = EXT_W'(accNextRe);
      wide[1] = EXT_W'(accNextIm);
    end else if (ctrl.dual) begin
      wide[0] = EXT_W'(prod[0]);
      wide[1] = EXT_W'(prod[1]);
    end else begin
      wide[0] = EXT_W'(pRe);
      wide[1] = EXT_W'(pIm);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_sat
    assign narrow[g] = shiftSat(wide[g], shiftAmt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sumRe <= '0; sumIm <= '0; difRe <= '0; difIm <= '0;
    end else if (ctrl.capture) begin
      sumRe <= narrow[0];
      sumIm <= narrow[1];
      difRe <= narrow[2];
      difIm <= narrow[3];
    end
  end

endmodule

// File: rtl/cplx_bfly_mac.sv
module cplx_bfly_mac
  import cbm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inValid,
  input  logic [2:0]               opCode,
  input  logic [1:0]               shiftAmt,
  input  logic                     accClear,
  input  logic signed [DATA_W-1:0] xRe,
  input  logic signed [DATA_W-1:0] xIm,
  input  logic signed [DATA_W-1:0] yRe,
  input  logic signed [DATA_W-1:0] yIm,
  input  logic signed [DATA_W-1:0] wRe,
  input  logic signed [DATA_W-1:0] wIm,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] sumRe,
  output logic signed [DATA_W-1:0] sumIm,
  output logic signed [DATA_W-1:0] difRe,
  output logic signed [DATA_W-1:0] difIm,
  output logic signed [ACC_W-1:0]  accRe,
  output logic signed [ACC_W-1:0]  accIm,
  output logic                     opErr
);

  ctrl_t ctrl;

  cbm_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opCode(opCode),
    .accClear(accClear), .ctrl(ctrl), .outValid(outValid), .opErr(opErr)
  );

  cbm_datapath #(.DATA_W(DATA_W), .ACC_W(ACC_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .shiftAmt(shiftAmt),
    .xRe(xRe), .xIm(xIm), .yRe(yRe), .yIm(yIm), .wRe(wRe), .wIm(wIm),
    .sumRe(sumRe), .sumIm(sumIm), .difRe(difRe), .difIm(difIm),
    .accRe(accRe), .accIm(accIm)
  );

endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic [2:0]        opCode,
  input logic              accClear,
  input logic              outValid,
  input logic              opErr,
  input logic [DATA_W-1:0] sumRe,
  input logic [DATA_W-1:0] sumIm,
  input logic [DATA_W-1:0] difRe,
  input logic [DATA_W-1:0] difIm,
  input logic [ACC_W-1:0]  accRe,
  input logic [ACC_W-1:0]  accIm
);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> (!outValid && $stable(sumRe) && $stable(sumIm) && $stable(difRe) && $stable(difIm)));

  a_r2_mul_no_dif: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opCode == 3'd0) |=> (difRe == '0 && difIm == '0));

  a_r4_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inValid && !accClear) |=> ($stable(accRe) && $stable(accIm)));

  a_r5_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (accClear && !inValid) |=> (accRe == '0 && accIm == '0));

  a_r10_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opCode > 3'd5) |=> (opErr && sumRe == '0 && sumIm == '0 && difRe == '0 && difIm == '0));

  a_r10_err_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opCode > 3'd5 && !accClear) |=> ($stable(accRe) && $stable(accIm)));

  a_r10_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opCode <= 3'd5) |=> !opErr);

endmodule

bind cplx_bfly_mac cbm_checker #(.DATA_W(DATA_W), .ACC_W(ACC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .opCode(opCode), .accClear(accClear),
  .outValid(outValid), .opErr(opErr), .sumRe(sumRe), .sumIm(sumIm),
  .difRe(difRe), .difIm(difIm), .accRe(accRe), .accIm(accIm)
);

// File: tb/cplx_bfly_mac_tb_top.sv
module cplx_bfly_mac_tb_top;

  localparam int DW = 16;
  localparam int AW = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [2:0] opCode = '0;
  logic [1:0] shiftAmt = '0;
  logic accClear = 1'b0;
  logic signed [DW-1:0] xRe = '0, xIm = '0, yRe = '0, yIm = '0, wRe = '0, wIm = '0;
  logic outValid, opErr;
  logic signed [DW-1:0] sumRe, sumIm, difRe, difIm;
  logic signed [AW-1:0] accRe, accIm;

  always #2.5 clk = ~clk;  // 200 MHz

  cplx_bfly_mac #(.DATA_W(DW), .ACC_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opCode(opCode), .shiftAmt(shiftAmt),
    .accClear(accClear), .xRe(xRe), .xIm(xIm), .yRe(yRe), .yIm(yIm), .wRe(wRe), .wIm(wIm),
    .outValid(outValid), .sumRe(sumRe), .sumIm(sumIm), .difRe(difRe), .difIm(difIm),
    .accRe(accRe), .accIm(accIm), .opErr(opErr)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [1:0] sh, input logic clr,
                       input logic signed [DW-1:0] xr, xi, yr, yi, wr, wi);
    @(negedge clk);
    opCode = op; shiftAmt = sh; accClear = clr; inValid = 1'b1;
    xRe = xr; xIm = xi; yRe = yr; yIm = yi; wRe = wr; wIm = wi;
    @(negedge clk);
    inValid = 1'b0; accClear = 1'b0;
  endtask

  typedef struct packed {
    logic [2:0] op;
    logic [1:0] sh;
    logic signed [DW-1:0] xr, xi, yr, yi, wr, wi;
    logic signed [DW-1:0] sr, si, dr, di;
    logic err;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    // R2: (2-1i)(3+4i) = 10+5i
    '{3'd0, 2'd0,    0,   0,   3,  4,    2, -1,    10,     5,    0,   0, 1'b0, 8'd2},
    // R3: butterfly with X = 100-50i
    '{3'd2, 2'd0,  100, -50,   3,  4,    2, -1,   110,   -45,   90, -55, 1'b0, 8'd3},
    // R9: butterfly, shift 1, odd negatives floor
    '{3'd2, 2'd1,    7, -10,   1,  0,    0,  1,     3,    -5,    3,  -6, 1'b0, 8'd9},
    // R6: (2-3i)(4+5i) = 23-2i
    '{3'd3, 2'd0,    2,   3,   4,  5,    9,  9,    23,    -2,    0,   0, 1'b0, 8'd6},
    // R7: (2-3i)(4-5i) = -7-22i
    '{3'd4, 2'd0,    2,   3,   4,  5,    9,  9,    -7,   -22,    0,   0, 1'b0, 8'd7},
    // R8: dual real lanes
    '{3'd5, 2'd0,   -6,   7,   5, -3,    1,  1,   -30,   -21,    0,   0, 1'b0, 8'd8},
    // R10: undefined code 6
    '{3'd6, 2'd0,    5,   5,   5,  5,    5,  5,     0,     0,    0,   0, 1'b1, 8'd10},
    // R10: undefined code 7
    '{3'd7, 2'd2,   -5,   9,   3,  2,    7,  1,     0,     0,    0,   0, 1'b1, 8'd10},
    // R9: positive clamp 40000 -> 32767
    '{3'd0, 2'd0,    0,   0, 200,  0,  200,  0, 32767,     0,    0,   0, 1'b0, 8'd9},
    // R9: negative clamp -40000 -> -32768
    '{3'd0, 2'd0,    0,   0, 200,  0, -200,  0, -32768,    0,    0,   0, 1'b0, 8'd9},
    // R9: shift 3 brings 40000 into range
    '{3'd0, 2'd3,    0,   0, 200,  0,  200,  0,  5000,     0,    0,   0, 1'b0, 8'd9}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    string rq;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "outValid", outValid, 0);
    chk("R11", "sumRe", sumRe, 0);
    chk("R11", "accRe", accRe, 0);
    chk("R11", "opErr", opErr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      rq = $sformatf("R%0d", VECS[i].req);
      apply(VECS[i].op, VECS[i].sh, 1'b0, VECS[i].xr, VECS[i].xi,
            VECS[i].yr, VECS[i].yi, VECS[i].wr, VECS[i].wi);
      chk("R1", "outValid", outValid, 1);
      chk(rq, "sumRe", sumRe, VECS[i].sr);
      chk(rq, "sumIm", sumIm, VECS[i].si);
      chk(rq, "difRe", difRe, VECS[i].dr);
      chk(rq, "difIm", difIm, VECS[i].di);
      chk(rq, "opErr", opErr, VECS[i].err);
    end

    // R1: hold while idle
    apply(3'd2, 2'd0, 1'b0, 100, -50, 3, 4, 2, -1);
    @(negedge clk);
    chk("R1", "outValid idle", outValid, 0);
    chk("R1", "sumRe held", sumRe, 110);
    chk("R1", "difIm held", difIm, -55);

    // R2: multiply loads the accumulator with the product
    apply(3'd0, 2'd0, 1'b0, 0, 0, 3, 4, 2, -1);
    chk("R2", "accRe load", accRe, 10);
    chk("R2", "accIm load", accIm, 5);

    // R5: clear with accumulate -> product only; R4 accumulation order
    apply(3'd1, 2'd0, 1'b1, 0, 0, 3, 4, 2, -1);
    chk("R5", "accRe clr+mac", accRe, 10);
    chk("R5", "accIm clr+mac", accIm, 5);
    apply(3'd1, 2'd0, 1'b0, 0, 0, 3, 4, 2, -1);
    chk("R4", "accRe 2", accRe, 20);
    chk("R4", "sumIm 2", sumIm, 10);
    apply(3'd1, 2'd2, 1'b0, 0, 0, 3, 4, 2, -1);
    chk("R4", "accRe 3", accRe, 30);
    chk("R4", "sumRe 3 shifted", sumRe, 7);
    chk("R4", "sumIm 3 shifted", sumIm, 3);
    // R10: undefined code leaves accumulator
    apply(3'd6, 2'd0, 1'b0, 1, 1, 1, 1, 1, 1);
    chk("R10", "accRe kept", accRe, 30);
    chk("R10", "accIm kept", accIm, 15);
    apply(3'd0, 2'd0, 1'b0, 0, 0, 1, 0, 1, 0);
    chk("R10", "opErr cleared", opErr, 0);
    // R5: clear alone
    @(negedge clk); accClear = 1'b1;
    @(negedge clk); accClear = 1'b0;
    chk("R5", "accRe cleared", accRe, 0);
    chk("R5", "accIm cleared", accIm, 0);

    // R4: saturating accumulation, 300 full-scale products
    for (int k = 0; k < 300; k++)
      apply(3'd1, 2'd0, (k == 0), 0, 0, -32768, 32767, -32768, -32768);
    chk("R4", "accRe saturated", accRe, 64'sd549755813887);
    chk("R4", "accIm exact", accIm, 64'sd9830400);
    chk("R4", "sumRe clamped", sumRe, 32767);

    // R12: conjugating the most negative imaginary part
    apply(3'd3, 2'd0, 1'b0, 0, -32768, 1, 0, 0, 0);
    chk("R12", "sumIm clamp", sumIm, 32767);
    apply(3'd3, 2'd1, 1'b0, 0, -32768, 1, 0, 0, 0);
    chk("R12", "sumIm shift1", sumIm, 16384);
    apply(3'd4, 2'd0, 1'b0, 0, 0, 0, -32768, 0, 0);
    chk("R12", "sumRe zero", sumRe, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule